// File: doc/BRIEF.md
# Shared PCI Interrupt Steering Router

This block takes the four active-low, wire-shared PCI interrupt request lines of a system board and steers each onto one of sixteen active-high system IRQ outputs. Firmware programs one routing entry per line over a small register bus. Each entry chooses a target IRQ from a short list of legal codes. Code 0 disables the line, and code 13 is reserved: a line routed there is accepted but reaches no output. Each entry also chooses a trigger mode. In level mode the output follows the request line. In edge mode a request is captured once on its assertion edge and is held as a pending bit until software writes 1 to clear it.

The request lines pass through a two-flop synchronizer first. When several lines target the same IRQ, their requests are ORed onto that output. Each edge-mode line is tracked by a small capture state machine with three states:

- `CAP_QUIET`: no request is held and the line is released.
- `CAP_LATCHED`: a request is pending.
- `CAP_SPENT`: the line is still held low, but its request has already been taken or cleared.

The state machine has these transitions:

- QUIET→LATCHED when the line becomes active in edge mode.
- LATCHED→QUIET when software clears the request and the line is released.
- LATCHED→SPENT when software clears the request and the line is still low.
- SPENT→QUIET when the line is released.
- In level mode the machine is forced to SPENT while the line is active and to QUIET otherwise. As a result, switching a held line into edge mode creates no request.

Top module: `irq_steer_router`

## Requirements
- R1: After reset the entries read back as input 0→9, 1→10, 2→11, 3→7, all in level mode. The pending register reads 0, and every IRQ output is low.
- R2: In level mode, a low request on a line drives its routed IRQ output high by the third clock edge. The output drops by the third edge after every line mapped to that IRQ is released.
- R3: An entry with code 0 delivers nothing from its line.
- R4: An entry with code 13 delivers nothing from its line. IRQ outputs other than 7, 9, 10 and 11 never go high.
- R5: A routing write is ignored, and the entry is kept, if its code is not one of {0,7,9,10,11,13} or if any of data bits [7:5] is set.
- R6: Requests from several lines routed to the same IRQ are ORed onto that output.
- R7: In edge mode, the assertion edge of a line sets its pending bit and keeps its IRQ high after the line is released. A line that stays low after being cleared raises nothing more. Switching a line that is already low into edge mode raises nothing.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it set.
- R9: Register layout: address i (0 to 3) holds the entry for line i, with the code in bits [3:0] and the edge-mode select in bit 4. Address 4 holds the pending bits of lines 0 to 3 in bits [3:0]; writing 1 to a bit clears it. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n_i | input | 4 | Shared interrupt request lines, active low, bit i is line i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_o | output | 16 | System IRQ requests, bit n is IRQ n, active high |

## Verification
The bench builds the router with its default parameters: four lines, sixteen outputs, two synchronizer stages and the reset table 9/10/11/7. These values let every legal code, the disabled code, the reserved code and the illegal codes be reached through the register bus. Sharing is exercised by pointing a second line at IRQ 9. All three capture states are visited through held, released and re-asserted requests around clears. The bench also covers a mode switch while a line is held low.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int CODE_W  = 4;
    localparam int ENTRY_W = CODE_W + 1;

    // IRQ numbers that actually reach an output (7, 9, 10, 11)
    localparam logic [15:0] DELIVER_MASK = 16'h0E80;

    typedef enum logic [1:0] {
        CAP_QUIET   = 2'd0,
        CAP_LATCHED = 2'd1,
        CAP_SPENT   = 2'd2
    } cap_state_t;

    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        return (c == 4'd0) || (c == 4'd7) || (c == 4'd9) ||
               (c == 4'd10) || (c == 4'd11) || (c == 4'd13);
    endfunction

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_n,
    output logic [WIDTH-1:0] active
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
        end else begin
            chain_q[0] <= req_n;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign active = ~chain_q[STAGES-1];
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_router_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter logic [NUM_IN*CODE_W-1:0] DEFAULT_ROUTE = 16'h7BA9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_IN*CODE_W-1:0]   codes,
    output logic [NUM_IN-1:0]          edge_mode
);
    logic write_ok;
    assign write_ok = (wdata[DATA_W-1:ENTRY_W] == '0) && code_legal(wdata[CODE_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            codes     <= DEFAULT_ROUTE;
            edge_mode <= '0;
        end else if (wr && write_ok) begin
            for (int i = 0; i < NUM_IN; i++) begin
                if (addr == ADDR_W'(i)) begin
                    codes[i*CODE_W +: CODE_W] <= wdata[CODE_W-1:0];
                    edge_mode[i]              <= wdata[CODE_W];
                end
            end
        end
    end
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic edge_en,
    input  logic clr,
    output logic pend
);
    cap_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!edge_en) begin
            state_d = active ? CAP_SPENT : CAP_QUIET;
        end else begin
            unique case (state_q)
                CAP_QUIET:   if (active) state_d = CAP_LATCHED;
                CAP_LATCHED: if (clr)    state_d = active ? CAP_SPENT : CAP_QUIET;
                CAP_SPENT:   if (!active) state_d = CAP_QUIET;
                default:     state_d = CAP_QUIET;
            endcase
        end
    end

    assign pend = (state_q == CAP_LATCHED);
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_router_pkg::*;
#(
    parameter int NUM_IN      = 4,
    parameter int NUM_IRQ     = 16,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_IN*CODE_W-1:0] DEFAULT_ROUTE = 16'h7BA9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IN-1:0]  req_n_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [NUM_IRQ-1:0] irq_o
);
    localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NUM_IN);

    logic [NUM_IN-1:0]        act_w;
    logic [NUM_IN-1:0]        pend_w;
    logic [NUM_IN-1:0]        edge_w;
    logic [NUM_IN-1:0]        req_w;
    logic [NUM_IN*CODE_W-1:0] table_w;
    logic                     clr_wr;

    irq_req_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_n(req_n_i), .active(act_w)
    );

    irq_route_table #(
        .NUM_IN(NUM_IN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEFAULT_ROUTE(DEFAULT_ROUTE)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr_i), .addr(reg_addr_i),
        .wdata(reg_wdata_i), .codes(table_w), .edge_mode(edge_w)
    );

    assign clr_wr = reg_wr_i && (reg_addr_i == PEND_ADDR);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_cap
        irq_edge_capture u_cap (
            .clk(clk), .rst_n(rst_n), .active(act_w[i]), .edge_en(edge_w[i]),
            .clr(clr_wr && reg_wdata_i[i]), .pend(pend_w[i])
        );
        assign req_w[i] = edge_w[i] ? pend_w[i] : act_w[i];
    end

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
        if (k < 16 && DELIVER_MASK[k % 16]) begin : g_live
            always_comb begin
                irq_o[k] = 1'b0;
                for (int i = 0; i < NUM_IN; i++)
                    if (table_w[i*CODE_W +: CODE_W] == CODE_W'(k) && req_w[i]) irq_o[k] = 1'b1;
            end
        end else begin : g_dead
            assign irq_o[k] = 1'b0;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == PEND_ADDR) begin
            reg_rdata_o[NUM_IN-1:0] = pend_w;
        end else begin
            for (int i = 0; i < NUM_IN; i++) begin
                if (reg_addr_i == ADDR_W'(i)) begin
                    reg_rdata_o[CODE_W-1:0] = table_w[i*CODE_W +: CODE_W];
                    reg_rdata_o[CODE_W]     = edge_w[i];
                end
            end
        end
    end
endmodule

// File: rtl/irq_steer_router_chk.sv
module irq_steer_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_IRQ = 16,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr_i,
    input logic [ADDR_W-1:0]          reg_addr_i,
    input logic [DATA_W-1:0]          reg_wdata_i,
    input logic [NUM_IRQ-1:0]         irq_o,
    input logic [NUM_IN-1:0]          act_w,
    input logic [NUM_IN-1:0]          pend_w,
    input logic [NUM_IN-1:0]          edge_w,
    input logic [NUM_IN*CODE_W-1:0]   table_w
);
    localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NUM_IN);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w == '0 && pend_w == '0) |-> (irq_o == '0));

    assert_reserved_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_o & ~NUM_IRQ'(DELIVER_MASK)) == 0);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
        assert_keep_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_i && reg_addr_i == ADDR_W'(i) &&
             !code_legal(reg_wdata_i[CODE_W-1:0]))
            |=> $stable(table_w[i*CODE_W +: CODE_W]));

        assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_w[i] && edge_w[i] &&
             !(reg_wr_i && reg_addr_i == PEND_ADDR && reg_wdata_i[i]) &&
             !(reg_wr_i && reg_addr_i == ADDR_W'(i)))
            |=> pend_w[i]);

        assert_clear_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_w[i] && reg_wr_i && reg_addr_i == PEND_ADDR && reg_wdata_i[i])
            |=> !pend_w[i]);
    end
endmodule

bind irq_steer_router irq_steer_router_chk #(
    .NUM_IN(NUM_IN), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .act_w(act_w), .pend_w(pend_w),
    .edge_w(edge_w), .table_w(table_w)
);

// File: tb/irq_steer_router_bench.sv
module irq_steer_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_n = 4'hF;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [15:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_steer_router u_irq_steer_router (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = 8'd0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk);
        req_n[i] = v;
        wait_cyc(4);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        reg_read(3'd0, d); check("R1 entry0", d, 8'h09);
        reg_read(3'd1, d); check("R1 entry1", d, 8'h0A);
        reg_read(3'd2, d); check("R1 entry2", d, 8'h0B);
        reg_read(3'd3, d); check("R9 entry3", d, 8'h07);
        reg_read(3'd4, d); check("R1 pending", d, 8'h00);
        check("R1 irq idle", irq, 16'h0000);
    endtask

    task automatic t_level;
        set_line(0, 1'b0); check("R2 level assert", irq, 16'h0200);
        set_line(2, 1'b0); check("R2 two lines", irq, 16'h0A00);
        set_line(0, 1'b1); set_line(2, 1'b1);
        check("R2 level release", irq, 16'h0000);
    endtask

    task automatic t_share;
        reg_write(3'd1, 8'h09);
        set_line(0, 1'b0); set_line(1, 1'b0);
        check("R6 shared both", irq, 16'h0200);
        set_line(0, 1'b1); check("R6 shared one left", irq, 16'h0200);
        set_line(1, 1'b1); check("R6 shared released", irq, 16'h0000);
        reg_write(3'd1, 8'h0A);
    endtask

    task automatic t_disable;
        logic [7:0] d;
        reg_write(3'd2, 8'h00);
        reg_read(3'd2, d); check("R3 readback", d, 8'h00);
        set_line(2, 1'b0); check("R3 disabled silent", irq, 16'h0000);
        set_line(2, 1'b1);
        reg_write(3'd2, 8'h0B);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        reg_write(3'd3, 8'h0D);
        reg_read(3'd3, d); check("R4 readback", d, 8'h0D);
        set_line(3, 1'b0); check("R4 reserved silent", irq, 16'h0000);
        set_line(3, 1'b1);
        reg_write(3'd3, 8'h17);
        set_line(3, 1'b0); check("R4 edge to 7", irq, 16'h0080);
        set_line(3, 1'b1);
        reg_write(3'd4, 8'h08);
        reg_write(3'd3, 8'h07);
    endtask

    task automatic t_illegal;
        logic [7:0] d;
        reg_write(3'd0, 8'h08);
        reg_read(3'd0, d); check("R5 code 8 ignored", d, 8'h09);
        reg_write(3'd0, 8'h1F);
        reg_read(3'd0, d); check("R5 code 15 ignored", d, 8'h09);
        reg_write(3'd0, 8'h2B);
        reg_read(3'd0, d); check("R5 high bits ignored", d, 8'h09);
        set_line(0, 1'b0); check("R5 still level to 9", irq, 16'h0200);
        set_line(0, 1'b1);
    endtask

    task automatic t_edge;
        logic [7:0] d;
        set_line(0, 1'b0);
        reg_write(3'd0, 8'h19);
        wait_cyc(3);
        reg_read(3'd4, d); check("R7 held line no request", d, 8'h00);
        check("R7 held line irq", irq, 16'h0000);
        set_line(0, 1'b1);
        set_line(0, 1'b0);
        reg_read(3'd4, d); check("R7 pending set", d, 8'h01);
        set_line(0, 1'b1); check("R7 latched after release", irq, 16'h0200);
        reg_write(3'd4, 8'h00);
        reg_read(3'd4, d); check("R8 zero write keeps", d, 8'h01);
        reg_write(3'd4, 8'h01);
        reg_read(3'd4, d); check("R8 cleared", d, 8'h00);
        check("R8 irq dropped", irq, 16'h0000);
        set_line(0, 1'b0);
        reg_write(3'd4, 8'h01);
        wait_cyc(6);
        reg_read(3'd4, d); check("R7 held after clear", d, 8'h00);
        check("R7 no repeat irq", irq, 16'h0000);
        set_line(0, 1'b1); set_line(0, 1'b0);
        check("R7 new edge", irq, 16'h0200);
        set_line(0, 1'b1);
        reg_write(3'd4, 8'h01);
        reg_write(3'd0, 8'h09);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_level();
        t_share();
        t_disable();
        t_reserved();
        t_illegal();
        t_edge();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule